// File: doc/BRIEF.md
# Command Cycle Status Tracker

This block sits between a host bus and a command-processing engine and owns the 4-bit status word the host sees. The host writes command words into a small register window. Each write word carries one parity bit. A clean write to the last command-word address launches a command. The block pulses a start strobe to the engine, holds the status at Busy, and turns the engine's done/result handshake into the final status. At launch it also samples the 2-bit response from a cascaded slave device, to find out whether the slave saw the request.

The host can read the status at either of two addresses. A status read closes the command cycle, and the status then changes to "command cycle error" on purpose. The only exception is a read taken while Busy. If the host reads again without launching a new command, it sees that error and learns that a command start was missed.

Status encoding: bits [3:2] give the class: 00 = OK, 01 = Busy, 10 = Alarm, 11 = error. Under Alarm, bits [1:0] carry the engine's 2-bit detail. Under error, bits [1:0] give the cause: 00 = parity, 01 = cascade, 10 = command cycle. Busy and OK carry 00.

Top module: `cmd_status_tracker`

## Requirements
- R1: After synchronous reset, the status is 0000 (OK) and the start strobe is low.
- R2: A read at address 6 or 7 returns the current status in the same cycle. If the status was not Busy, it becomes 1110 (command cycle error) on the next cycle.
- R3: A status read while Busy leaves the status at 0100.
- R4: When writes are accepted, a write to addresses 0..5 whose data and parity bit together have an odd number of ones sets the status to 1100 (parity error). The command is discarded and no start strobe is raised.
- R5: In the parity error state every write is ignored: the status stays 1100 and no start is raised. Only a status read leaves the state, and it moves to 1110.
- R6: From OK, Alarm, cascade error or command cycle error, a clean write to address 5 raises the start strobe for exactly one cycle, in the cycle the status becomes 0100.
- R7: A write while Busy raises no start and keeps the status at 0100. When the engine then reports done, the status becomes 1110, whatever the result.
- R8: Engine done while Busy sets the status to {10, detail} when the alarm flag is high, and to 0000 otherwise.
- R9: If the slave response sampled at the launching write is 00 (request not seen), done sets the status to 1101 (cascade error). An earlier write while Busy (R7) takes priority over this.
- R10: In single-device mode, an accepted write with address bit 13 set (range 0x2000..0x3FFF) sets the status to 1101 at once and raises no start. In two-device mode, such a write leaves the status unchanged.
- R11: Engine done outside Busy has no effect on the status.
- R12: A clean write to addresses 0..4 changes neither the status nor the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe; takes priority over a simultaneous write |
| bus_addr | input | ADDR_W (14) | Host local address |
| bus_wdata | input | DATA_W (16) | Host write data |
| bus_wpar | input | 1 | Parity bit; data plus this bit must hold an even number of ones |
| single_dev | input | 1 | 1 = no second device is fitted |
| casc_resp | input | 2 | Slave response, 00 = request not seen |
| eng_start | output | 1 | One-cycle command launch strobe |
| eng_done | input | 1 | Engine finished the command |
| eng_alarm | input | 1 | Engine result is an alarm |
| eng_detail | input | 2 | Engine alarm detail |
| stat_word | output | 4 | Current status word (read data at addresses 6 and 7) |

## Verification
A wrong internal state shows at stat_word on the cycle after the access that caused it, because the status register drives the port directly. A lost or extra launch shows on eng_start in that same cycle. Effects the bus cannot see at once are the Busy-write flag and the sampled slave miss. The bench therefore follows every launch through to done and reads the resulting code. Each sweep then does a status read and a following read, so a missed transition to command cycle error shows within two accesses.

// File: rtl/ccst_pkg.sv
// Package: shared status encodings for the command cycle status tracker.
// Assumes a 4-bit status word: [3:2] class, [1:0] detail.
package ccst_pkg;
    typedef enum logic [1:0] {
        CLS_OK    = 2'b00,
        CLS_BUSY  = 2'b01,
        CLS_ALARM = 2'b10,
        CLS_ERR   = 2'b11
    } stat_cls_e;

    localparam logic [1:0] ERR_PARITY = 2'b00;
    localparam logic [1:0] ERR_CASC   = 2'b01;
    localparam logic [1:0] ERR_CYCLE  = 2'b10;

    localparam logic [3:0] STAT_OK    = {CLS_OK,   2'b00};
    localparam logic [3:0] STAT_BUSY  = {CLS_BUSY, 2'b00};
    localparam logic [3:0] STAT_PAR   = {CLS_ERR,  ERR_PARITY};
    localparam logic [3:0] STAT_CASC  = {CLS_ERR,  ERR_CASC};
    localparam logic [3:0] STAT_CYCLE = {CLS_ERR,  ERR_CYCLE};
endpackage

// File: rtl/ccst_addr_decode.sv
// Address decoder: classifies a host address as command word, launch
// word, status location or upper (second-device) range.
// Assumes the register window sits at the bottom of the lower half and
// the top address bit selects the second device.
module ccst_addr_decode #(
    parameter int ADDR_W   = 14,
    parameter int LAST_CMD = 5,
    parameter int STAT_A   = 6,
    parameter int STAT_B   = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_cmd,
    output logic              is_last,
    output logic              is_stat,
    output logic              is_upper
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_CMD);
    localparam logic [ADDR_W-1:0] STA_A  = ADDR_W'(STAT_A);
    localparam logic [ADDR_W-1:0] STB_A  = ADDR_W'(STAT_B);

    // Pure compare logic for the four address classes.
    always_comb begin
        is_cmd   = (addr <= LAST_A);
        is_last  = (addr == LAST_A);
        is_stat  = (addr == STA_A) || (addr == STB_A);
        is_upper = addr[ADDR_W-1];
    end
endmodule

// File: rtl/ccst_parity.sv
// Parity checker: flags a word whose data plus parity bit breaks the
// configured parity sense. Assumes one parity bit covers the whole word.
module ccst_parity #(
    parameter int DATA_W   = 16,
    parameter bit ODD_SENSE = 1'b0
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              bad
);
    logic ones_odd;

    // Reduction over data and parity bit.
    always_comb ones_odd = ^{data, par};

    generate
        if (ODD_SENSE) begin : g_odd
            // Odd sense: an even count is an error.
            always_comb bad = ~ones_odd;
        end else begin : g_even
            // Even sense: an odd count is an error.
            always_comb bad = ones_odd;
        end
    endgenerate
endmodule

// File: rtl/ccst_status_fsm.sv
// Status controller: holds the status word and moves it on host accesses
// and engine completion; launches commands.
// Assumes a single host access per cycle (a read wins over a write).
module ccst_status_fsm
    import ccst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       is_cmd,
    input  logic       is_last,
    input  logic       is_stat,
    input  logic       is_upper,
    input  logic       par_bad,
    input  logic       single_dev,
    input  logic [1:0] casc_resp,
    input  logic       eng_done,
    input  logic       eng_alarm,
    input  logic [1:0] eng_detail,
    output logic [3:0] status,
    output logic       start
);
    logic [3:0] status_d;
    logic       start_d;
    logic       wr_err_q, wr_err_d;
    logic       casc_miss_q, casc_miss_d;
    logic       busy, in_par, rd_stat, wr_acc;

    // State qualifiers used by the next-state logic.
    always_comb begin
        busy    = (status[3:2] == CLS_BUSY);
        in_par  = (status == STAT_PAR);
        rd_stat = rd_en && is_stat;
        wr_acc  = wr_en && !rd_en;
    end

    // Next status, launch strobe and per-command flags.
    always_comb begin
        status_d    = status;
        start_d     = 1'b0;
        wr_err_d    = wr_err_q;
        casc_miss_d = casc_miss_q;
        if (busy) begin
            if (wr_acc) wr_err_d = 1'b1;
            if (eng_done) begin
                if (wr_err_d)        status_d = STAT_CYCLE;
                else if (casc_miss_q) status_d = STAT_CASC;
                else if (eng_alarm)  status_d = {CLS_ALARM, eng_detail};
                else                 status_d = STAT_OK;
            end
        end else if (rd_stat) begin
            status_d = STAT_CYCLE;
        end else if (wr_acc && !in_par) begin
            if (is_upper && single_dev) begin
                status_d = STAT_CASC;
            end else if (is_cmd) begin
                if (par_bad) begin
                    status_d = STAT_PAR;
                end else if (is_last) begin
                    status_d    = STAT_BUSY;
                    start_d     = 1'b1;
                    wr_err_d    = 1'b0;
                    casc_miss_d = (casc_resp == 2'b00);
                end
            end
        end
    end

    // Registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status      <= STAT_OK;
            start       <= 1'b0;
            wr_err_q    <= 1'b0;
            casc_miss_q <= 1'b0;
        end else begin
            status      <= status_d;
            start       <= start_d;
            wr_err_q    <= wr_err_d;
            casc_miss_q <= casc_miss_d;
        end
    end

    // R2
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_stat && status[3:2] != CLS_BUSY) |=> status == STAT_CYCLE);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == CLS_BUSY && !eng_done) |=> status[3:2] == CLS_BUSY);
    // R4
    par_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && is_cmd && par_bad && !is_upper
         && status[3:2] != CLS_BUSY && status != STAT_PAR) |=> status == STAT_PAR);
    // R5
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_PAR && !(rd_en && is_stat)) |=> status == STAT_PAR);
    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> status == STAT_BUSY);
    // R7
    busy_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == CLS_BUSY) |=> !start);
    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !wr_en && !rd_en && status[3:2] != CLS_BUSY) |=> $stable(status));
endmodule

// File: rtl/cmd_status_tracker.sv
// Top: command cycle status tracker. Decodes host accesses, checks write
// parity, and keeps the status word for the command engine handshake.
// Assumes single-cycle bus strobes and an engine that answers with done.
module cmd_status_tracker #(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16,
    parameter int LAST_CMD  = 5,
    parameter int STAT_A    = 6,
    parameter int STAT_B    = 7,
    parameter bit ODD_SENSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wpar,
    input  logic              single_dev,
    input  logic [1:0]        casc_resp,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic              eng_alarm,
    input  logic [1:0]        eng_detail,
    output logic [3:0]        stat_word
);
    logic is_cmd, is_last, is_stat, is_upper, par_bad;

    ccst_addr_decode #(
        .ADDR_W(ADDR_W), .LAST_CMD(LAST_CMD), .STAT_A(STAT_A), .STAT_B(STAT_B)
    ) u_dec (
        .addr(bus_addr), .is_cmd(is_cmd), .is_last(is_last),
        .is_stat(is_stat), .is_upper(is_upper)
    );

    ccst_parity #(.DATA_W(DATA_W), .ODD_SENSE(ODD_SENSE)) u_par (
        .data(bus_wdata), .par(bus_wpar), .bad(par_bad)
    );

    ccst_status_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .is_cmd(is_cmd), .is_last(is_last), .is_stat(is_stat),
        .is_upper(is_upper), .par_bad(par_bad), .single_dev(single_dev),
        .casc_resp(casc_resp), .eng_done(eng_done), .eng_alarm(eng_alarm),
        .eng_detail(eng_detail), .status(stat_word), .start(eng_start)
    );
endmodule

// File: tb/cmd_status_tracker_tb.sv
module cmd_status_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wpar = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        single_dev = 1'b0;
    logic [1:0]  casc_resp = 2'b01;
    logic        eng_done = 1'b0, eng_alarm = 1'b0;
    logic [1:0]  eng_detail = 2'b00;
    logic        eng_start;
    logic [3:0]  stat_word;
    int          n_chk = 0, n_bad = 0;
    logic        finished = 1'b0;

    cmd_status_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
        .single_dev(single_dev), .casc_resp(casc_resp), .eng_start(eng_start),
        .eng_done(eng_done), .eng_alarm(eng_alarm), .eng_detail(eng_detail),
        .stat_word(stat_word)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [15:0] d, input bit good);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wpar = (^d) ^ !good;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [3:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = stat_word;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic done(input logic al, input logic [1:0] det);
        eng_done = 1'b1; eng_alarm = al; eng_detail = det;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // Launch, then finish with the given result.
    task automatic run_cmd(input logic [1:0] resp, input logic al, input logic [1:0] det);
        casc_resp = resp;
        wr(14'd5, 16'h1234, 1'b1);
        chk("R6", {3'b0, eng_start}, 4'b0001);
        chk("R6", stat_word, 4'b0100);
        done(al, det);
        chk("R6", {3'b0, eng_start}, 4'b0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", stat_word, 4'b0000);
        chk("R1", {3'b0, eng_start}, 4'b0000);

        // R11: done while idle is ignored
        done(1'b1, 2'b11);
        chk("R11", stat_word, 4'b0000);

        // R2: read at both addresses
        rd(14'd6, v); chk("R2", v, 4'b0000); chk("R2", stat_word, 4'b1110);
        rd(14'd7, v); chk("R2", v, 4'b1110); chk("R2", stat_word, 4'b1110);

        // R12: clean words 0..4 leave status alone
        for (int a = 0; a < 5; a++) begin
            wr(14'(a), 16'(a * 37 + 5), 1'b1);
            chk("R12", stat_word, 4'b1110);
            chk("R12", {3'b0, eng_start}, 4'b0000);
        end

        // R4/R5: bad parity at every command address
        for (int a = 0; a < 6; a++) begin
            wr(14'(a), 16'(16'hA5A0 + a), 1'b0);
            chk("R4", stat_word, 4'b1100);
            chk("R4", {3'b0, eng_start}, 4'b0000);
            wr(14'd5, 16'h0F0F, 1'b1);
            chk("R5", stat_word, 4'b1100);
            chk("R5", {3'b0, eng_start}, 4'b0000);
            single_dev = 1'b1;
            wr(14'h2000, 16'h0001, 1'b1);
            single_dev = 1'b0;
            chk("R5", stat_word, 4'b1100);
            rd(14'(6 + (a % 2)), v);
            chk("R5", v, 4'b1100);
            chk("R5", stat_word, 4'b1110);
        end

        // R8: alarm detail sweep and OK result
        for (int d = 0; d < 4; d++) begin
            run_cmd(2'b01, 1'b1, 2'(d));
            chk("R8", stat_word, {2'b10, 2'(d)});
        end
        run_cmd(2'b10, 1'b0, 2'b00);
        chk("R8", stat_word, 4'b0000);

        // R9: slave response sweep
        for (int r = 0; r < 4; r++) begin
            run_cmd(2'(r), 1'b1, 2'b01);
            chk("R9", stat_word, (r == 0) ? 4'b1101 : 4'b1001);
        end

        // R3/R7: read and write while busy
        casc_resp = 2'b00;
        wr(14'd5, 16'h0003, 1'b1);
        rd(14'd6, v); chk("R3", v, 4'b0100); chk("R3", stat_word, 4'b0100);
        wr(14'd5, 16'h0003, 1'b1);
        chk("R7", stat_word, 4'b0100);
        chk("R7", {3'b0, eng_start}, 4'b0000);
        done(1'b1, 2'b10);
        chk("R7", stat_word, 4'b1110);

        // R10: upper range in both configurations
        run_cmd(2'b01, 1'b0, 2'b00);
        single_dev = 1'b0;
        wr(14'h3FFF, 16'h0000, 1'b1);
        chk("R10", stat_word, 4'b0000);
        single_dev = 1'b1;
        wr(14'h2005, 16'h0000, 1'b1);
        chk("R10", stat_word, 4'b1101);
        chk("R10", {3'b0, eng_start}, 4'b0000);
        single_dev = 1'b0;
        // R6: launch from cascade error
        run_cmd(2'b11, 1'b0, 2'b00);
        chk("R6", stat_word, 4'b0000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule